// File: doc/BRIEF.md
# Serial EEPROM I2C Target

This block is a bus target that looks, from the two-wire serial bus, like a small byte-wide serial EEPROM. It watches a synchronized clock line and data line, spots START and STOP conditions, checks the control byte against its device code and strap pins, and acknowledges by pulling the data line low through an open-drain output-enable. In a write, the first byte after the control byte sets the internal word pointer. The data bytes that follow collect in a page buffer, and a STOP commits that buffer to an internal byte array. In a read, the target shifts bytes out from the word pointer and keeps going for as long as the bus master acknowledges.

Each committed write starts a busy interval of a fixed number of system clocks. During that interval the target refuses to acknowledge any control byte, so a master can poll for the end of the write cycle. A write-protect input stops any change to the array. The three select bits of the control byte are shared between strap matching and block selection. The upper `3-BLOCK_BITS` of them must equal the straps, and the lower `BLOCK_BITS` of them choose a 256-byte block of the array.

All data moves over the bus, and the bus master sets its pace bit by bit. For that reason the block has no valid/ready stream interface. Its control pins are plain levels.

Top module: `eep_target`

## Requirements
- R1: After reset, `sda_oe_o` is low, and every array byte reads back as 0xFF.
- R2: The target acknowledges a control byte only when its four MSBs are 1010 and its select bits [3:1], outside the block bits, equal `strap_i`. In every other case it leaves `sda_oe_o` low until the next START.
- R3: Control bits [BLOCK_BITS:1] select the array block. With the defaults (BLOCK_BITS=1), control bit 1 picks block 0 or block 1. A write to one block leaves the same word in the other block unchanged.
- R4: Control bit 0 sets the direction: 1 reads and 0 writes.
- R5: In a write, the target acknowledges the word-address byte and every data byte. Each data byte goes to the word pointer. The pointer then advances only in its low log2(PAGE_BYTES) bits and wraps within the page.
- R6: Buffered data reaches the array only at a STOP. A repeated START discards it and does not start a busy interval.
- R7: While `wp_i` is high at the STOP, the array does not change and no busy interval starts.
- R8: After a STOP that commits at least one byte, the target acknowledges no control byte for BUSY_CYCLES clocks. After that it acknowledges again.
- R9: A read drives bytes MSB first, starting from the word pointer. After each byte the pointer steps by one modulo 256. Reading continues while the master acknowledges, and the target releases the data line after a master NACK.
- R10: A START or STOP in the middle of a byte drops that byte, restarts the bit count, and returns the target to control-byte matching or to idle. The word pointer is left unchanged.
- R11: `sda_oe_o` rises only in the clock after a falling edge of SCL, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (wired-AND level) |
| strap_i | input | 3 | Hardware address strap pins |
| wp_i | input | 1 | Write protect; high blocks array updates |
| sda_oe_o | output | 1 | Open-drain enable; high pulls the data line low |

## Verification
Almost every fault in the sequencer shows at the ports within one byte time. A wrong bit count or state appears as a missing or extra acknowledge in the very next ninth clock, or as a shifted read byte. Faults in the page buffer or the commit path stay hidden until a later read returns the wrong value at the wrong word, so every write is followed by a read-back of the words it touched and of their neighbours in the page and in the other block. A busy timer that runs short or never starts shows up as the acknowledge to an immediate poll right after the STOP. A timer that runs long shows up as a missing acknowledge after the interval has expired.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // Select bits outside the block mask must equal the straps.
  function automatic logic sel_match(input logic [2:0] sel,
                                     input logic [2:0] strap,
                                     input logic [2:0] blk_mask);
    return ((sel ^ strap) & ~blk_mask) == 3'b000;
  endfunction

endpackage

// File: rtl/eep_line_watch.sv
module eep_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int PAGE_BYTES  = 16,
  parameter int BLOCK_BITS  = 1,
  parameter int BUSY_CYCLES = 400,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int AW     = 8 + BLOCK_BITS,
  localparam int PN_W   = AW - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clear,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [7:0]        buf_din,
  input  logic              commit,
  input  logic              wp,
  input  logic [PN_W-1:0]   page_no,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);

  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            mem   [DEPTH];
  logic [7:0]            pbuf  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [CNT_W-1:0]      cnt;
  logic [AW-1:0]         wr_idx [PAGE_BYTES];
  logic                  do_commit;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    assign wr_idx[g] = {page_no, PAGE_W'(g)};
  end

  assign do_commit = commit & (|pvalid) & ~wp;

  // Page buffer: slot data with a valid mask, emptied by START or STOP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
    end else if (buf_clear || commit) begin
      pvalid <= '0;
    end else if (buf_we) begin
      pbuf[buf_idx]   <= buf_din;
      pvalid[buf_idx] <= 1'b1;
    end
  end

  // Array: every valid slot is written in the single commit clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid[i]) mem[wr_idx[i]] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (do_commit)      cnt <= CNT_W'(BUSY_CYCLES);
    else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
  end

  assign busy    = (cnt != '0);
  assign rd_data = mem[rd_addr];

  assert_wp_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wp && !busy) |=> !busy);

  assert_busy_counts_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_start_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> (pvalid == '0));

endmodule

// File: rtl/eep_target.sv
module eep_target #(
  parameter int PAGE_BYTES  = 16,
  parameter int BLOCK_BITS  = 1,
  parameter int BUSY_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  import eep_pkg::*;

  localparam int         PAGE_W    = $clog2(PAGE_BYTES);
  localparam int         AW        = 8 + BLOCK_BITS;
  localparam logic [2:0] BLK_MASK  = 3'((1 << BLOCK_BITS) - 1);
  localparam logic [7:0] PAGE_MASK = 8'(PAGE_BYTES - 1);

  eep_state_e  state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [7:0]  txbyte;
  logic [7:0]  word;
  logic [2:0]  blk;
  logic        acking;
  logic        oe;

  logic        scl_rise, scl_fall, start_det, stop_det;
  logic        busy;
  logic        ctrl_ok;
  logic        byte_end;
  logic        buf_we;
  logic        commit;
  logic [AW-1:0] mem_addr;
  logic [7:0]  rd_data;

  eep_line_watch u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign mem_addr = AW'({blk, word});
  assign byte_end = scl_fall && (bitcnt == 4'd8) && !acking;
  assign buf_we   = byte_end && (state == ST_WDATA) && !start_det && !stop_det;
  assign commit   = stop_det && (state == ST_WDATA);
  assign ctrl_ok  = (shreg[7:4] == DEV_CODE) &&
                    sel_match(shreg[3:1], strap_i, BLK_MASK) && !busy;

  eep_store #(
    .PAGE_BYTES  (PAGE_BYTES),
    .BLOCK_BITS  (BLOCK_BITS),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_clear (start_det),
    .buf_we    (buf_we),
    .buf_idx   (word[PAGE_W-1:0]),
    .buf_din   (shreg),
    .commit    (commit),
    .wp        (wp_i),
    .page_no   (mem_addr[AW-1:PAGE_W]),
    .rd_addr   (mem_addr),
    .rd_data   (rd_data),
    .busy      (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      shreg  <= 8'h00;
      txbyte <= 8'h00;
      word   <= 8'h00;
      blk    <= 3'b000;
      acking <= 1'b0;
      oe     <= 1'b0;
    end else if (start_det) begin
      state  <= ST_CTRL;
      bitcnt <= 4'd0;
      acking <= 1'b0;
      oe     <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      acking <= 1'b0;
      oe     <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (state != ST_RDATA) shreg <= {shreg[6:0], sda_i};
        end else if (bitcnt == 4'd8) begin
          if (acking || state != ST_RDATA) begin
            bitcnt <= 4'd9;
          end else begin
            // master acknowledge slot of a read byte
            word <= word + 8'd1;
            if (sda_i) begin
              state  <= ST_IDLE;
              bitcnt <= 4'd0;
            end else begin
              bitcnt <= 4'd9;
            end
          end
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd9) begin
          bitcnt <= 4'd0;
          acking <= 1'b0;
          if (state == ST_RDATA) begin
            txbyte <= rd_data;
            oe     <= ~rd_data[7];
          end else begin
            oe <= 1'b0;
          end
        end else if (byte_end) begin
          unique case (state)
            ST_CTRL: begin
              if (ctrl_ok) begin
                blk    <= shreg[3:1] & BLK_MASK;
                acking <= 1'b1;
                oe     <= 1'b1;
                state  <= shreg[0] ? ST_RDATA : ST_WADDR;
              end else begin
                state  <= ST_IDLE;
                bitcnt <= 4'd0;
              end
            end
            ST_WADDR: begin
              word   <= shreg;
              acking <= 1'b1;
              oe     <= 1'b1;
              state  <= ST_WDATA;
            end
            ST_WDATA: begin
              word   <= (word & ~PAGE_MASK) | ((word + 8'd1) & PAGE_MASK);
              acking <= 1'b1;
              oe     <= 1'b1;
            end
            ST_RDATA: oe <= 1'b0;
            default:  oe <= 1'b0;
          endcase
        end else if (state == ST_RDATA && bitcnt != 4'd0 && bitcnt < 4'd8) begin
          oe <= ~txbyte[3'(4'd7 - bitcnt)];
        end
      end
    end
  end

  assign sda_oe_o = oe;

  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(scl_fall));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !oe);

  assert_no_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && state == ST_CTRL && busy && !start_det && !stop_det) |=> !oe);

  assert_bitcnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bitcnt == 4'd0 && state == ST_CTRL && !oe));

endmodule

// File: tb/eep_target_tb.sv
module eep_target_tb;

  localparam int BUSY = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       md = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       wp = 1'b0;
  logic       oe;
  logic       sda;

  int checks = 0;
  int errors = 0;
  bit quiet = 1'b1;
  bit done = 1'b0;

  // behavioural model state
  logic [7:0] mmem [512];
  int         ptr = 0;
  int         pa[$];
  logic [7:0] pv[$];
  logic [7:0] wdat [4];

  always #5 clk = ~clk;
  assign sda = md & ~oe;

  eep_target #(.PAGE_BYTES(16), .BLOCK_BITS(1), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the bus rules
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_oe && oe && prev_scl && scl) check(1'b0, "R11 oe rose with SCL high", oe, 0);
      if (quiet && oe) check(1'b0, "R2 unexpected drive", oe, 0);
    end
    prev_oe  = oe;
    prev_scl = scl;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    md = 1'b1; tick(2); scl = 1'b1; tick(4); md = 1'b0; tick(4); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    md = 1'b0; tick(2); scl = 1'b1; tick(4); md = 1'b1; tick(6);
  endtask

  task automatic clk_bit(input bit b, output bit s);
    tick(2); md = b; tick(6); scl = 1'b1; tick(4); s = sda; tick(4); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
    clk_bit(!mack, s);
  endtask

  function automatic logic [7:0] ctrl(input int blk, input bit rd);
    return {4'b1010, 2'b10, 1'(blk), rd};
  endfunction

  // write: control, word address, n data bytes, then STOP or repeated START
  task automatic write_tx(input int blk, input int addr, input int n, input bit end_stop);
    bit a;
    quiet = 1'b0;
    bus_start();
    send_byte(ctrl(blk, 1'b0), a); check(a, "R4 write control ack", a, 1);
    send_byte(8'(addr), a);        check(a, "R5 word address ack", a, 1);
    ptr = addr;
    pa.delete(); pv.delete();
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], a); check(a, "R5 data ack", a, 1);
      pa.push_back(blk * 256 + ptr); pv.push_back(wdat[k]);
      ptr = (ptr & 8'hF0) | ((ptr + 1) & 8'h0F);
    end
    if (end_stop) begin
      bus_stop();
      if (!wp) foreach (pa[i]) mmem[pa[i]] = pv[i];
    end
    pa.delete(); pv.delete();
  endtask

  task automatic read_tx(input int blk, input int n);
    bit a, s;
    logic [7:0] v;
    logic [7:0] e;
    quiet = 1'b0;
    bus_start();
    send_byte(ctrl(blk, 1'b1), a); check(a, "R4 read control ack", a, 1);
    for (int k = 0; k < n; k++) begin
      e = mmem[blk * 256 + ptr];
      recv_byte(k < n - 1, v);
      check(v === e, "R9 read data", v, e);
      ptr = (ptr + 1) & 255;
    end
    quiet = 1'b1;
    clk_bit(1'b1, s); check(s, "R9 released after NACK", s, 1);
    bus_stop();
  endtask

  task automatic set_ptr(input int blk, input int addr);
    bit a;
    quiet = 1'b0;
    bus_start();
    send_byte(ctrl(blk, 1'b0), a); check(a, "R5 pointer control ack", a, 1);
    send_byte(8'(addr), a);        check(a, "R5 pointer address ack", a, 1);
    ptr = addr;
  endtask

  task automatic poll(input bit exp_ack, input string req);
    bit a;
    quiet = !exp_ack;
    bus_start();
    send_byte(ctrl(0, 1'b0), a);
    check(a == exp_ack, req, a, exp_ack);
    bus_stop();
    quiet = 1'b1;
  endtask

  initial begin
    bit a, s;
    for (int i = 0; i < 512; i++) mmem[i] = 8'hFF;
    tick(4);
    check(oe == 1'b0, "R1 oe low in reset", oe, 0);
    rst_n = 1'b1;
    tick(10);
    check(oe == 1'b0, "R1 oe low after reset", oe, 0);

    // R1: erased contents
    set_ptr(0, 8'h10);
    read_tx(0, 2);

    // R2: wrong strap, wrong device code
    quiet = 1'b1;
    bus_start();
    send_byte(8'hA4, a); check(!a, "R2 strap mismatch nack", a, 0);
    send_byte(8'h55, a); check(!a, "R2 stays silent", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB9, a); check(!a, "R2 code mismatch nack", a, 0);
    bus_stop();

    // R5: page write wrapping from 0x0E to 0x00
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    write_tx(0, 8'h0E, 3, 1'b1);
    poll(1'b0, "R8 busy nack right after commit");
    tick(BUSY + 20);
    poll(1'b1, "R8 ack after busy interval");
    set_ptr(0, 8'h0E);
    read_tx(0, 4);
    set_ptr(0, 8'h00);
    read_tx(0, 2);

    // R3: block select
    wdat[0] = 8'h5A;
    write_tx(1, 8'h0E, 1, 1'b1);
    tick(BUSY + 20);
    set_ptr(0, 8'h0E);
    read_tx(0, 1);
    check(mmem[14] == 8'h11, "R3 other block kept", mmem[14], 8'h11);
    set_ptr(1, 8'h0E);
    read_tx(1, 1);

    // R7: write protect
    wp = 1'b1;
    wdat[0] = 8'hC3;
    write_tx(0, 8'h20, 1, 1'b1);
    poll(1'b1, "R7 no busy under protect");
    wp = 1'b0;
    set_ptr(0, 8'h20);
    read_tx(0, 1);

    // R6: repeated START discards the buffer
    wdat[0] = 8'h77;
    write_tx(0, 8'h30, 1, 1'b0);
    read_tx(0, 1);
    poll(1'b1, "R6 no busy after discard");
    set_ptr(0, 8'h30);
    read_tx(0, 1);

    // R10: START mid-byte, then STOP mid-byte
    quiet = 1'b1;
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(i[0], s);
    quiet = 1'b0;
    bus_start();
    send_byte(ctrl(0, 1'b0), a); check(a, "R10 ack after mid-byte START", a, 1);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop();
    quiet = 1'b1;
    tick(20);
    read_tx(0, 2);

    quiet = 1'b1;
    tick(20);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule